// File: doc/BRIEF.md
# Single-Source Interrupt Relay with Acknowledge Release and Retrigger

The block turns one local interrupt request into a request on one of seven backplane interrupt lines. A programmable level selects which line is driven, and level 0 turns generation off. A rising edge on the local request sets a pending flag. While the flag is set, the selected line is driven. When the bus master runs an interrupt-acknowledge cycle at the matching level, the block returns an 8-bit status/ID vector and drops the line: the request is released by the acknowledge itself.

Some local sources do not clear their request when the handler runs. To cover this, every accepted acknowledge starts a timer, 1 ms by default. When the timer runs out and the local request is still high, the block raises the line again. If the acknowledge level on the address lines does not match the programmed level, the block does not answer the cycle. It signals that the acknowledge is to be passed on down the chain. A build-time option takes the level and the vector from input ports instead of from the internal registers.

Top module: `intr_relay`

## Requirements
- R1: After reset, `irq_drive`, `iack_accept`, `iack_pass` and `vec_out` are all zero, and the internal level and vector registers hold 0.
- R2: Levels 1 to 7 each select one line: bit k-1 of `irq_drive` corresponds to line k. When the level is nonzero, a 0-to-1 change of `req_in` that is sampled at a clock edge makes `irq_drive` equal to the one-hot code of the level from that edge on. At most one bit of `irq_drive` is ever set. A request that stays high does not create a new request by itself.
- R3: Level 0 disables the block: a rising edge of `req_in` drives no line. Setting the level to 0 while a request is pending clears the pending request, so restoring a nonzero level later does not bring that request back.
- R4: An acknowledge is accepted when `iack_strobe` is sampled high, a request is pending, and `iack_level` equals the programmed level. On the edge that samples the strobe, `iack_accept` goes high for one cycle, `vec_out` takes the programmed vector, and `irq_drive` returns to zero.
- R5: A strobe that is not accepted, because of a level mismatch or because no request is pending, makes `iack_pass` go high for one cycle after the sampling edge. In that case `iack_accept` stays low and the pending request keeps being driven.
- R6: N = ceil(RETRIG_NS / CLK_PERIOD_NS) clock cycles, with a minimum of 1. If `req_in` is still high when the timer expires, the selected line is driven again from the N-th edge after the accepting edge.
- R7: If `req_in` is low when the timer expires, no line is driven again.
- R8: Every accepted acknowledge restarts the retrigger interval, and a new rising edge of `req_in` cancels an interval that is running. Only the interval started by the latest acknowledge can raise the line again.
- R9: With EXT_CFG = 1, the level comes from `ext_level` and the vector from `ext_vec`. Writes through `cfg_level_we`/`cfg_vec_we` then have no effect on the lines driven or on the vector returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_in | input | 1 | Local interrupt request, synchronous to clk |
| cfg_level_we | input | 1 | Write strobe for the internal level register |
| cfg_level_din | input | 3 | Level value to write |
| cfg_vec_we | input | 1 | Write strobe for the internal vector register |
| cfg_vec_din | input | 8 | Vector value to write |
| ext_level | input | 3 | Level used when EXT_CFG = 1 |
| ext_vec | input | 8 | Vector used when EXT_CFG = 1 |
| iack_strobe | input | 1 | Interrupt-acknowledge cycle present this clock |
| iack_level | input | 3 | Level being acknowledged, from the address lines |
| irq_drive | output | 7 | Active-high line drive; bit k-1 corresponds to line k |
| iack_accept | output | 1 | One-cycle pulse: acknowledge taken by this block |
| iack_pass | output | 1 | One-cycle pulse: acknowledge to be passed on |
| vec_out | output | 8 | Status/ID vector, valid while iack_accept is high |

## Verification
The line drive changes combinationally from the pending flag, so it follows a request edge, an accepted acknowledge or a level change at the first clock edge that samples the stimulus. The accept and pass pulses and the vector are registered at that same edge. A retrigger appears at the N-th edge after the accepting edge, with N worked out in the bench from the two timing parameters. The bench drives inputs just after falling edges and samples at the falling edge that follows the edge where a result is due. For the retrigger, it checks the line both one half cycle before and one half cycle after the N-th edge.

// File: rtl/intr_relay_pkg.sv
package intr_relay_pkg;

  parameter int unsigned IRQ_LINES = 7;
  localparam int unsigned LVL_W = $clog2(IRQ_LINES + 1);

  typedef logic [LVL_W-1:0]     level_t;
  typedef logic [IRQ_LINES-1:0] lines_t;

  // one-hot line select; level 0 selects nothing
  function automatic lines_t line_select(input level_t lvl);
    lines_t sel;
    for (int i = 0; i < int'(IRQ_LINES); i++) begin
      sel[i] = (lvl == LVL_W'(i + 1));
    end
    return sel;
  endfunction

  // retrigger interval in cycles, rounded up, at least one
  function automatic int unsigned retrig_cycles(input int unsigned period_ns,
                                                input int unsigned interval_ns);
    int unsigned r;
    r = (interval_ns + period_ns - 1) / period_ns;
    if (r == 0) r = 1;
    return r;
  endfunction

endpackage

// File: rtl/intr_cfg_src.sv
module intr_cfg_src
  import intr_relay_pkg::*;
#(
  parameter int unsigned VEC_W   = 8,
  parameter bit          EXT_CFG = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             level_we,
  input  level_t           level_din,
  input  logic             vec_we,
  input  logic [VEC_W-1:0] vec_din,
  input  level_t           ext_level,
  input  logic [VEC_W-1:0] ext_vec,
  output level_t           level,
  output logic [VEC_W-1:0] vector
);

  generate
    if (EXT_CFG) begin : g_ext
      logic unused_wr;
      assign unused_wr = ^{clk, rst_n, level_we, level_din, vec_we, vec_din};
      assign level  = ext_level;
      assign vector = ext_vec;
    end else begin : g_int
      level_t           level_q;
      logic [VEC_W-1:0] vec_q;
      logic unused_ext;
      assign unused_ext = ^{ext_level, ext_vec};

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          level_q <= '0;
          vec_q   <= '0;
        end else begin
          if (level_we) level_q <= level_din;
          if (vec_we)   vec_q   <= vec_din;
        end
      end

      assign level  = level_q;
      assign vector = vec_q;
    end
  endgenerate

endmodule

// File: rtl/intr_edge_det.sv
module intr_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic req_in,
  output logic rise
);

  logic req_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) req_prev <= 1'b0;
    else        req_prev <= req_in;
  end

  assign rise = req_in & ~req_prev;

  // R2
  rise_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/intr_retrig_timer.sv
module intr_retrig_timer #(
  parameter int unsigned CYCLES = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic cancel,
  output logic expire
);

  localparam int unsigned CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt;
  logic             armed;

  assign expire = armed && (cnt == CNT_W'(1)) && !load && !cancel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (load) begin
      cnt   <= CNT_W'(CYCLES);
      armed <= 1'b1;
    end else if (cancel || expire) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (armed) begin
      cnt   <= cnt - CNT_W'(1);
    end
  end

  // R6
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (cnt != '0) && (cnt <= CNT_W'(CYCLES)));

  // R8
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> armed && (cnt == CNT_W'(CYCLES)));

endmodule

// File: rtl/intr_ack_match.sv
module intr_ack_match
  import intr_relay_pkg::*;
#(
  parameter int unsigned VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  level_t           ack_level,
  input  level_t           level,
  input  logic             pending,
  input  logic [VEC_W-1:0] vector,
  output logic             hit,
  output logic             accept,
  output logic             pass,
  output logic [VEC_W-1:0] vec_out
);

  assign hit = strobe && pending && (level != '0) && (ack_level == level);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      accept  <= 1'b0;
      pass    <= 1'b0;
      vec_out <= '0;
    end else begin
      accept <= hit;
      pass   <= strobe && !hit;
      if (hit) vec_out <= vector;
    end
  end

  // R4
  accept_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> accept && (vec_out == $past(vector)));

  // R5
  mismatch_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && (ack_level != level)) |=> pass && !accept);

  // R4
  ack_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && pass));

endmodule

// File: rtl/intr_relay.sv
module intr_relay
  import intr_relay_pkg::*;
#(
  parameter int unsigned VEC_W         = 8,
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter int unsigned RETRIG_NS     = 1000000,
  parameter bit          EXT_CFG       = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_in,
  input  logic                 cfg_level_we,
  input  logic [LVL_W-1:0]     cfg_level_din,
  input  logic                 cfg_vec_we,
  input  logic [VEC_W-1:0]     cfg_vec_din,
  input  logic [LVL_W-1:0]     ext_level,
  input  logic [VEC_W-1:0]     ext_vec,
  input  logic                 iack_strobe,
  input  logic [LVL_W-1:0]     iack_level,
  output logic [IRQ_LINES-1:0] irq_drive,
  output logic                 iack_accept,
  output logic                 iack_pass,
  output logic [VEC_W-1:0]     vec_out
);

  localparam int unsigned RETRIG_CYC = retrig_cycles(CLK_PERIOD_NS, RETRIG_NS);

  level_t           lvl;
  logic [VEC_W-1:0] vector;
  logic             rise;
  logic             hit;
  logic             tmr_expire;
  logic             pending;
  logic             retrig_set;

  intr_cfg_src #(.VEC_W(VEC_W), .EXT_CFG(EXT_CFG)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .level_we  (cfg_level_we),
    .level_din (cfg_level_din),
    .vec_we    (cfg_vec_we),
    .vec_din   (cfg_vec_din),
    .ext_level (ext_level),
    .ext_vec   (ext_vec),
    .level     (lvl),
    .vector    (vector)
  );

  intr_edge_det u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_in (req_in),
    .rise   (rise)
  );

  intr_retrig_timer #(.CYCLES(RETRIG_CYC)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (hit),
    .cancel (rise),
    .expire (tmr_expire)
  );

  intr_ack_match #(.VEC_W(VEC_W)) u_ack (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (iack_strobe),
    .ack_level (iack_level),
    .level     (lvl),
    .pending   (pending),
    .vector    (vector),
    .hit       (hit),
    .accept    (iack_accept),
    .pass      (iack_pass),
    .vec_out   (vec_out)
  );

  assign retrig_set = tmr_expire && req_in;

  // a new request wins over an acknowledge in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n)                  pending <= 1'b0;
    else if (lvl == '0)          pending <= 1'b0;
    else if (rise || retrig_set) pending <= 1'b1;
    else if (hit)                pending <= 1'b0;
  end

  assign irq_drive = pending ? line_select(lvl) : '0;

  // R2
  drive_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_drive));

  // R2
  rise_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && (lvl != '0)) |=> pending);

  // R3
  level_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == '0) |=> !pending);

  // R6
  retrig_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retrig_set && (lvl != '0)) |=> pending);

  // R4
  accept_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !rise && !retrig_set) |=> !pending);

endmodule

// File: tb/intr_relay_bench.sv
module intr_relay_bench;

  localparam int unsigned PER_NS = 10;
  localparam int unsigned RT_NS  = 200;
  localparam int unsigned N      = (RT_NS + PER_NS - 1) / PER_NS;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_in = 1'b0, req_x = 1'b0;
  logic       lvl_we = 1'b0, vec_we = 1'b0;
  logic [2:0] lvl_din = '0;
  logic [7:0] vec_din = '0;
  logic [2:0] ext_level = 3'd6;
  logic [7:0] ext_vec = 8'hC3;
  logic       strb = 1'b0, strb_x = 1'b0;
  logic [2:0] ack_lvl = '0, ack_lvl_x = '0;
  logic [6:0] drive, drive_x;
  logic       acc, acc_x, pas, pas_x;
  logic [7:0] vout, vout_x;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  intr_relay #(.CLK_PERIOD_NS(PER_NS), .RETRIG_NS(RT_NS)) u_intr_relay (
    .clk(clk), .rst_n(rst_n), .req_in(req_in),
    .cfg_level_we(lvl_we), .cfg_level_din(lvl_din),
    .cfg_vec_we(vec_we), .cfg_vec_din(vec_din),
    .ext_level(ext_level), .ext_vec(ext_vec),
    .iack_strobe(strb), .iack_level(ack_lvl),
    .irq_drive(drive), .iack_accept(acc), .iack_pass(pas), .vec_out(vout)
  );

  intr_relay #(.CLK_PERIOD_NS(PER_NS), .RETRIG_NS(RT_NS), .EXT_CFG(1'b1)) u_intr_relay_ext (
    .clk(clk), .rst_n(rst_n), .req_in(req_x),
    .cfg_level_we(lvl_we), .cfg_level_din(lvl_din),
    .cfg_vec_we(vec_we), .cfg_vec_din(vec_din),
    .ext_level(ext_level), .ext_vec(ext_vec),
    .iack_strobe(strb_x), .iack_level(ack_lvl_x),
    .irq_drive(drive_x), .iack_accept(acc_x), .iack_pass(pas_x), .vec_out(vout_x)
  );

  function automatic logic [6:0] exp_line(input int lvl);
    return (lvl == 0) ? 7'd0 : 7'(1 << (lvl - 1));
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_level(input logic [2:0] l);
    lvl_we = 1'b1; lvl_din = l; tick(1); lvl_we = 1'b0;
  endtask

  task automatic set_vec(input logic [7:0] v);
    vec_we = 1'b1; vec_din = v; tick(1); vec_we = 1'b0;
  endtask

  task automatic ack(input logic [2:0] l);
    strb = 1'b1; ack_lvl = l; tick(1); strb = 1'b0;
  endtask

  task automatic t_reset();
    check(drive == 0 && acc == 0 && pas == 0 && vout == 0, "R1 outputs", {drive, acc, pas, vout}, 0);
    check(drive_x == 0 && acc_x == 0 && pas_x == 0, "R1 ext outputs", {drive_x, acc_x, pas_x}, 0);
    req_in = 1'b1; tick(1); req_in = 1'b0;
    check(drive == 0, "R1 level reg zero", drive, 0);
    tick(1);
  endtask

  task automatic t_basic_retrig();
    set_level(3'd3); set_vec(8'h5A);
    req_in = 1'b1; tick(1);
    check(drive == exp_line(3), "R2 drive level 3", drive, exp_line(3));
    tick(3);
    check(drive == exp_line(3), "R2 held drive", drive, exp_line(3));
    ack(3'd3);
    check(acc == 1'b1, "R4 accept", acc, 1);
    check(vout == 8'h5A, "R4 vector", vout, 8'h5A);
    check(drive == 0, "R4 release", drive, 0);
    tick(1);
    check(acc == 1'b0, "R4 one-cycle accept", acc, 0);
    tick(N - 2);
    check(drive == 0, "R6 before expiry", drive, 0);
    tick(1);
    check(drive == exp_line(3), "R6 retrigger", drive, exp_line(3));
    ack(3'd3);
    req_in = 1'b0;
    tick(N + 2);
    check(drive == 0, "R7 quiet source", drive, 0);
  endtask

  task automatic t_mismatch();
    set_level(3'd5); set_vec(8'h96);
    req_in = 1'b1; tick(1);
    check(drive == exp_line(5), "R2 drive level 5", drive, exp_line(5));
    ack(3'd2);
    check(pas == 1'b1 && acc == 1'b0, "R5 mismatch pass", {pas, acc}, 2'b10);
    check(drive == exp_line(5), "R5 still driven", drive, exp_line(5));
    ack(3'd5);
    check(acc == 1'b1 && vout == 8'h96, "R4 accept level 5", {acc, vout}, {1'b1, 8'h96});
    req_in = 1'b0;
    ack(3'd5);
    check(pas == 1'b1 && acc == 1'b0, "R5 not pending pass", {pas, acc}, 2'b10);
    tick(N + 2);
  endtask

  task automatic t_restart();
    set_level(3'd7);
    req_in = 1'b1; tick(1);
    ack(3'd7);
    tick(4);
    req_in = 1'b0; tick(1);
    req_in = 1'b1; tick(1);
    check(drive == exp_line(7), "R8 new edge drive", drive, exp_line(7));
    ack(3'd7);
    tick(N - 1);
    check(drive == 0, "R8 old interval ignored", drive, 0);
    tick(1);
    check(drive == exp_line(7), "R8 restarted interval", drive, exp_line(7));
    ack(3'd7);
    req_in = 1'b0;
    tick(N + 2);
  endtask

  task automatic t_level_zero();
    set_level(3'd0);
    req_in = 1'b1; tick(2);
    check(drive == 0, "R3 disabled", drive, 0);
    req_in = 1'b0; tick(1);
    set_level(3'd4);
    req_in = 1'b1; tick(1);
    check(drive == exp_line(4), "R2 drive level 4", drive, exp_line(4));
    set_level(3'd0);
    check(drive == 0, "R3 zero releases", drive, 0);
    set_level(3'd4);
    tick(1);
    check(drive == 0, "R3 pending cleared", drive, 0);
    req_in = 1'b0; tick(1);
  endtask

  task automatic t_ext();
    set_level(3'd2); set_vec(8'h11);
    req_x = 1'b1; tick(1);
    check(drive_x == exp_line(6), "R9 ext level", drive_x, exp_line(6));
    strb_x = 1'b1; ack_lvl_x = 3'd2; tick(1); strb_x = 1'b0;
    check(pas_x == 1'b1 && acc_x == 1'b0, "R9 internal level ignored", {pas_x, acc_x}, 2'b10);
    strb_x = 1'b1; ack_lvl_x = 3'd6; tick(1); strb_x = 1'b0;
    check(acc_x == 1'b1 && vout_x == 8'hC3, "R9 ext vector", {acc_x, vout_x}, {1'b1, 8'hC3});
    req_x = 1'b0; tick(1);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_basic_retrig();
    t_mismatch();
    t_restart();
    t_level_zero();
    t_ext();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule